// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block holds the state and arithmetic of a 32-bit processor that runs one instruction over several clock cycles. It runs a small subset: word loads and stores, register-to-register ALU operations, branch-if-equal and absolute jump. A single memory port serves both instruction fetch and data access. A single ALU is reused from cycle to cycle. Holding registers keep each unit's result until the next cycle needs it: the instruction register, the memory data register, the two operand registers and the ALU output register.

The block has no sequencing logic. An external controller drives its select and enable inputs every cycle. The datapath returns the opcode and function fields of the current instruction and a zero flag from the ALU. A typical sequence runs as follows:

- Fetch, with PC advanced by four in the same cycle.
- Decode, with operand read and branch target precomputation.
- Execute.
- Memory access or register write, depending on the instruction.
- A final write of loaded data.

The memory sits outside the block. It is read combinationally and written on the clock edge.

Top module: `mc_datapath`

## Requirements
- R1: While reset is low and right after it is released, PC, IR, MDR, A, B, ALUOut and every register are zero. So with all controls at zero, mem_addr, mem_wdata, opcode and funct read zero and zero reads 1.
- R2: mem_addr is PC when sel_addr_alu is 0 and ALUOut when it is 1. mem_wdata is the B register. mem_we follows ctl_mem_wr.
- R3: When ir_we is high, IR loads mem_rdata at the clock edge; otherwise it holds its value. opcode is IR[31:26] and funct is IR[5:0].
- R4: Every cycle, A loads the register addressed by IR[25:21] and B loads the register addressed by IR[20:16]. Register 0 always reads as zero.
- R5: ALU input A is PC when srca_reg is 0 and the A register when it is 1. ALU input B is chosen by srcb_sel: 0 selects B, 1 selects the constant 4, 2 selects sign-extended IR[15:0], and 3 selects the same value shifted left by 2. alu_op selects the operation: 0 add, 1 subtract, 2 AND, 3 OR, 4 signed set-less-than (result 1 or 0). Any other code gives zero.
- R6: Every cycle, ALUOut loads the ALU result. zero is 1 exactly when the current ALU result is zero.
- R7: PC loads at the edge when pc_we is high, or when pc_cond is high and zero is 1; otherwise it holds. The loaded value is chosen by pc_sel: 0 selects the ALU result, 1 selects ALUOut, and 2 selects the upper 4 bits of PC joined to IR[25:0] and two zero bits.
- R8: When rf_we is high, the register file writes ALUOut (wb_mem 0) or MDR (wb_mem 1). The destination is the register at IR[15:11] when dst_rd is 1 and at IR[20:16] when it is 0. A write to register 0 has no effect.
- R9: Every cycle, MDR loads mem_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_pc_we | input | 1 | Unconditional PC load |
| ctl_pc_cond | input | 1 | PC load qualified by zero |
| ctl_pc_sel | input | 2 | PC source select |
| ctl_addr_alu | input | 1 | Memory address from ALUOut instead of PC |
| ctl_mem_wr | input | 1 | Memory write request |
| ctl_ir_we | input | 1 | IR load enable |
| ctl_rf_we | input | 1 | Register file write enable |
| ctl_dst_rd | input | 1 | Write destination from IR[15:11] |
| ctl_wb_mem | input | 1 | Write data from MDR instead of ALUOut |
| ctl_srca_reg | input | 1 | ALU input A from A register instead of PC |
| ctl_srcb_sel | input | 2 | ALU input B select |
| ctl_alu_op | input | 3 | ALU operation code |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 32 | Memory read data |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| zero | output | 1 | ALU result is zero |

## Verification
The assertions do not assume the controller follows any legal step order. They assume only that every control input is a defined level in every cycle after reset. They also assume that mem_rdata is driven at all times, including during reset, so that the captures of IR and MDR compare against known values.

The bench acts as the controller and drives complete fetch, decode, execute, memory and write-back sequences for each instruction. It holds every control at zero outside those steps, and it inserts idle cycles only with all enables low. That keeps every random instruction within the control patterns a real sequencer would produce.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  localparam logic [1:0] SRCB_REG    = 2'd0;
  localparam logic [1:0] SRCB_FOUR   = 2'd1;
  localparam logic [1:0] SRCB_IMM    = 2'd2;
  localparam logic [1:0] SRCB_IMM_SH = 2'd3;

  localparam logic [1:0] PCS_ALU  = 2'd0;
  localparam logic [1:0] PCS_HOLD = 2'd1;
  localparam logic [1:0] PCS_JMP  = 2'd2;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] pc,
                                                  input logic [25:0] idx);
    return {pc[XLEN-1:XLEN-4], idx, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] alu_calc(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_SLT: r = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  assign y    = alu_calc(op, a, b);
  assign zero = (y == '0);

  always_comb begin
    if (op == ALU_SLT)
      AST_SLT_IS_BOOL: assert (y[W-1:1] == '0); // R5
    if (op == ALU_SUB && a == b)
      AST_SUB_EQ_ZERO: assert (zero); // R6
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_hardzero
      assign regs[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (!rst_n)
          regs[g] <= '0;
        else if (we && wa == AW'(g))
          regs[g] <= wd;
      end
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int             NREG     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_pc_we,
  input  logic        ctl_pc_cond,
  input  logic [1:0]  ctl_pc_sel,
  input  logic        ctl_addr_alu,
  input  logic        ctl_mem_wr,
  input  logic        ctl_ir_we,
  input  logic        ctl_rf_we,
  input  logic        ctl_dst_rd,
  input  logic        ctl_wb_mem,
  input  logic        ctl_srca_reg,
  input  logic [1:0]  ctl_srcb_sel,
  input  logic [2:0]  ctl_alu_op,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  input  logic [31:0] mem_rdata,
  output logic [5:0]  opcode,
  output logic [5:0]  funct,
  output logic        zero
);
  localparam int W  = XLEN;
  localparam int AW = $clog2(NREG);

  logic [W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
  logic [W-1:0] rf_rd1, rf_rd2, src_a, src_b, alu_res, pc_next, imm_ext, wb_data;
  logic [AW-1:0] wr_addr;
  logic          pc_load;
  logic          rf_write_live;

  // operand selection
  assign imm_ext = sext16(ir_q[15:0]);
  assign src_a   = ctl_srca_reg ? a_q : pc_q;

  always_comb begin
    case (ctl_srcb_sel)
      SRCB_REG:    src_b = b_q;
      SRCB_FOUR:   src_b = W'(4);
      SRCB_IMM:    src_b = imm_ext;
      default:     src_b = imm_ext << 2;
    endcase
  end

  mc_alu #(.W(W)) u_alu (
    .op   (alu_op_e'(ctl_alu_op)),
    .a    (src_a),
    .b    (src_b),
    .y    (alu_res),
    .zero (zero)
  );

  // next PC
  always_comb begin
    case (ctl_pc_sel)
      PCS_HOLD: pc_next = aluout_q;
      PCS_JMP:  pc_next = jump_target(pc_q, ir_q[25:0]);
      default:  pc_next = alu_res;
    endcase
  end
  assign pc_load = ctl_pc_we | (ctl_pc_cond & zero);

  // register file
  assign wr_addr       = ctl_dst_rd ? ir_q[15:11] : ir_q[20:16];
  assign wb_data       = ctl_wb_mem ? mdr_q : aluout_q;
  assign rf_write_live = ctl_rf_we && (wr_addr != '0);

  mc_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk (clk),
    .rst_n (rst_n),
    .ra1 (ir_q[25:21]),
    .ra2 (ir_q[20:16]),
    .rd1 (rf_rd1),
    .rd2 (rf_rd2),
    .we  (ctl_rf_we),
    .wa  (wr_addr),
    .wd  (wb_data)
  );

  // holding registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= RESET_PC;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      if (pc_load)   pc_q <= pc_next;
      if (ctl_ir_we) ir_q <= mem_rdata;
      mdr_q    <= mem_rdata;
      a_q      <= rf_rd1;
      b_q      <= rf_rd2;
      aluout_q <= alu_res;
    end
  end

  // memory side and decode fields
  assign mem_addr  = ctl_addr_alu ? aluout_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = ctl_mem_wr;
  assign opcode    = ir_q[31:26];
  assign funct     = ir_q[5:0];

  // assertions
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_pc_we && !ctl_pc_cond) |=> $stable(pc_q)); // R7
  AST_BRANCH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_pc_cond && zero && !ctl_pc_we && ctl_pc_sel == PCS_HOLD) |=> pc_q == $past(aluout_q)); // R7
  AST_IR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ir_we |=> ir_q == $past(mem_rdata)); // R3
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_ir_we |=> $stable(ir_q)); // R3
  AST_A_FROM_R0: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_q[25:21] == 5'd0) |=> a_q == '0); // R4
  AST_MDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> mdr_q == $past(mem_rdata)); // R9
  AST_R0_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rf_we && !rf_write_live && ir_q[25:21] == 5'd0) |=> a_q == '0); // R8
endmodule

// File: tb/mc_datapath_test.sv
module mc_datapath_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_pc_we, ctl_pc_cond, ctl_addr_alu, ctl_mem_wr, ctl_ir_we;
  logic        ctl_rf_we, ctl_dst_rd, ctl_wb_mem, ctl_srca_reg;
  logic [1:0]  ctl_pc_sel, ctl_srcb_sel;
  logic [2:0]  ctl_alu_op;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, zero;
  logic [5:0]  opcode, funct;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] rf [32];
  logic [31:0] dmem [64];
  logic [31:0] ref_pc;

  always #5 clk = ~clk;

  mc_datapath uut (.*);

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    report();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    ctl_pc_we = 0; ctl_pc_cond = 0; ctl_pc_sel = 0; ctl_addr_alu = 0; ctl_mem_wr = 0;
    ctl_ir_we = 0; ctl_rf_we = 0; ctl_dst_rd = 0; ctl_wb_mem = 0; ctl_srca_reg = 0;
    ctl_srcb_sel = 0; ctl_alu_op = 0; mem_rdata = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] ref_rtype(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      6'h20: return a + b;
      6'h22: return a - b;
      6'h24: return a & b;
      6'h25: return a | b;
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  function automatic logic [2:0] op_code_of(input logic [5:0] f);
    case (f)
      6'h20: return 3'd0;
      6'h22: return 3'd1;
      6'h24: return 3'd2;
      6'h25: return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd, input logic [5:0] f);
    return {6'h00, rs, rt, rd, 5'd0, f};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic run(input logic [31:0] ins);
    logic [4:0]  rs, rt, rd;
    logic [31:0] imm, ea, res;
    rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    imm = {{16{ins[15]}}, ins[15:0]};
    // fetch
    clr(); ctl_ir_we = 1; ctl_pc_we = 1; ctl_srcb_sel = 2'd1; mem_rdata = ins;
    #2; chk("R2 fetch address is PC", mem_addr, ref_pc);
    tick(); ref_pc = ref_pc + 4;
    // decode
    clr(); ctl_srcb_sel = 2'd3;
    #2; chk("R3 opcode field", {26'd0, opcode}, {26'd0, ins[31:26]});
    chk("R3 funct field", {26'd0, funct}, {26'd0, ins[5:0]});
    tick();
    case (ins[31:26])
      6'h00: begin
        res = ref_rtype(ins[5:0], rf[rs], rf[rt]);
        clr(); ctl_srca_reg = 1; ctl_alu_op = op_code_of(ins[5:0]);
        #2; chk("R6 zero flag on ALU result", {31'd0, zero}, {31'd0, res == 0});
        tick();
        clr(); ctl_rf_we = 1; ctl_dst_rd = 1;
        tick();
        if (rd != 0) rf[rd] = res;
      end
      6'h23, 6'h2B: begin
        ea = rf[rs] + imm;
        clr(); ctl_srca_reg = 1; ctl_srcb_sel = 2'd2;
        tick();
        clr(); ctl_addr_alu = 1;
        if (ins[31:26] == 6'h23) begin
          mem_rdata = dmem[ea[7:2]];
          #2; chk("R5 load effective address", mem_addr, ea);
          tick();
          clr(); ctl_rf_we = 1; ctl_wb_mem = 1; mem_rdata = $urandom;
          tick();
          if (rt != 0) rf[rt] = dmem[ea[7:2]];
        end else begin
          ctl_mem_wr = 1;
          #2; chk("R5 store effective address", mem_addr, ea);
          chk("R4 store data from B", mem_wdata, rf[rt]);
          chk("R2 write strobe", {31'd0, mem_we}, 32'd1);
          tick();
          dmem[ea[7:2]] = rf[rt];
        end
      end
      6'h04: begin
        clr(); ctl_srca_reg = 1; ctl_alu_op = 3'd1; ctl_pc_cond = 1; ctl_pc_sel = 2'd1;
        #2; chk("R6 branch compare zero", {31'd0, zero}, {31'd0, rf[rs] == rf[rt]});
        tick();
        if (rf[rs] == rf[rt]) ref_pc = ref_pc + (imm << 2);
      end
      default: begin
        clr(); ctl_pc_we = 1; ctl_pc_sel = 2'd2;
        tick();
        ref_pc = {ref_pc[31:28], ins[25:0], 2'b00};
      end
    endcase
    clr();
  endtask

  task automatic idle_hold();
    logic [5:0] op_before;
    op_before = opcode;
    clr(); mem_rdata = 32'hFFFF_FFFF;
    tick();
    #1; chk("R3 IR holds without enable", {26'd0, opcode}, {26'd0, op_before});
    chk("R7 PC holds without enable", mem_addr, ref_pc);
    clr();
  endtask

  function automatic logic [31:0] rand_instr();
    logic [5:0]  fs [5];
    logic [4:0]  rs, rt, rd;
    logic [15:0] imm;
    int k;
    fs[0] = 6'h20; fs[1] = 6'h22; fs[2] = 6'h24; fs[3] = 6'h25; fs[4] = 6'h2A;
    rs = 5'($urandom); rt = 5'($urandom); rd = 5'($urandom); imm = 16'($urandom);
    k = $urandom % 10;
    if (k < 4)  return enc_r(rs, rt, rd, fs[$urandom % 5]);
    if (k < 6)  return enc_i(6'h23, rs, rt, imm);
    if (k == 6) return enc_i(6'h2B, rs, rt, imm);
    if (k == 7) return enc_i(6'h04, rs, rt, imm);
    if (k == 8) return {6'h02, 26'($urandom)};
    return enc_i(6'h04, rs, rs, imm);
  endfunction

  initial begin
    void'($urandom(32'd2718));
    clr();
    for (int i = 0; i < 32; i++) rf[i] = 0;
    for (int i = 0; i < 64; i++) dmem[i] = $urandom;
    dmem[0] = 32'h8000_0000; dmem[1] = 32'h7FFF_FFFF; dmem[2] = 32'hFFFF_FFFF; dmem[3] = 32'd0;
    ref_pc = 0;
    repeat (3) @(posedge clk);
    #1;
    #2; chk("R1 reset mem_addr", mem_addr, 32'd0);
    chk("R1 reset opcode", {26'd0, opcode}, 32'd0);
    @(posedge clk); #1 rst_n = 1;
    #2;
    chk("R1 post-reset mem_addr", mem_addr, 32'd0);
    chk("R1 post-reset mem_wdata", mem_wdata, 32'd0);
    chk("R1 post-reset funct", {26'd0, funct}, 32'd0);
    chk("R1 post-reset zero", {31'd0, zero}, 32'd1);
    #1;
    // directed corners
    run(enc_i(6'h23, 5'd0, 5'd1, 16'd0));          // r1 = 0x80000000 (R9 via MDR)
    run(enc_i(6'h23, 5'd0, 5'd2, 16'd4));          // r2 = 0x7FFFFFFF
    run(enc_r(5'd1, 5'd2, 5'd3, 6'h2A));           // R5 signed slt -> 1
    run(enc_r(5'd2, 5'd1, 5'd4, 6'h2A));           // slt -> 0
    run(enc_r(5'd1, 5'd1, 5'd5, 6'h22));           // sub -> zero flag
    run(enc_r(5'd2, 5'd2, 5'd0, 6'h20));           // R8 write to r0 dropped
    run(enc_i(6'h2B, 5'd0, 5'd0, 16'd16));         // store r0, expect 0
    run(enc_i(6'h2B, 5'd0, 5'd3, 16'd20));
    run(enc_i(6'h2B, 5'd0, 5'd4, 16'd24));
    run(enc_i(6'h23, 5'd1, 5'd6, 16'hFFFC));       // negative offset from large base
    idle_hold();
    run(enc_i(6'h04, 5'd1, 5'd1, 16'hFFF0));       // R7 taken backward
    run(enc_i(6'h04, 5'd1, 5'd2, 16'h0040));       // not taken
    run({6'h02, 26'h3AB_CDEF});                    // R7 jump
    // random mix
    for (int n = 0; n < 400; n++) begin
      run(rand_instr());
      if (($urandom % 8) == 0) idle_hold();
    end
    // dump every register through stores (R4, R8)
    for (int r = 0; r < 32; r++) run(enc_i(6'h2B, 5'd0, 5'(r), 16'(r * 4)));
    report();
  end
endmodule